// File: doc/BRIEF.md
# Receive Page Ring Manager

This block manages the addressing of an 8 KB two-port packet buffer. The buffer is seen as 32 pages of 256 bytes. A boundary page number set at the input splits it. Pages below the boundary form a receive ring. The boundary page and every page above it are left for transmit data. The block does not hold the buffer memory itself. It produces the write address and write enable for each received byte. It also keeps the bookkeeping that allows a CPU to find, read and free stored frames, and it captures transmit requests.

The MAC side announces a frame with a start pulse that carries the frame length. The block then reserves enough whole pages for a 4-byte status word plus the data, or it drops the frame when the ring lacks room. Data bytes go to consecutive offsets after the status word. They run across page boundaries and wrap from the last receive page back to page 0. When the frame ends it is queued. The CPU reads a descriptor byte that holds the oldest frame's start page and page count. A release command frees that frame's pages. The transmit path collects a byte count and a start page from three byte writes. A transmit command then launches the send.

Top module: `rxpg_ring`

## Requirements
- R1: After reset, desc_o is 0, and rx_irq_o, tx_irq_o, missed_o and tx_go_o are all 0.
- R2: An accepted frame of length L occupies ceil((L+4)/256) pages, starting at the page that follows the last reserved page. After its end pulse it is queued. While it is the oldest queued frame, desc_o[4:0] holds its start page and desc_o[7:5] holds its page count.
- R3: Data byte i of an accepted frame is written with mem_we_o=1 at address page*256+offset, where offset = 4+i counted from the start page. The address moves to offset 0 of the next page after offset 255, and the page after part_page_i-1 is page 0.
- R4: A frame that needs more than 7 pages, or more pages than are free, is dropped. missed_o is 1 in the cycle after its start pulse, none of its bytes assert mem_we_o, and frames already stored keep their descriptors.
- R5: Command code 1 (cmd_i[3:0]=4'h1 with cmd_we_i) frees the oldest frame's pages. desc_o then shows the next frame, or a count of 0 and the next free page when the queue is empty. The same code with no queued frame changes nothing.
- R6: rx_irq_o is 1 exactly while at least one unreleased frame is queued.
- R7: Three writes on txd_i load, in order, the byte count MSB, the byte count LSB and the start page (low 5 bits). Command code 2 then gives a one-cycle tx_go_o with tx_len_o and tx_page_o holding the loaded values.
- R8: tx_done_i sets tx_irq_o. Command code 3 clears it. When both occur in the same cycle, the set takes precedence.
- R9: The receive ring is exactly pages 0 to part_page_i-1 (part_page_i from 1 to 31). A partition of 5'h17 gives 23 receive pages.
- R10: A start pulse while a frame is being stored is ignored. The current frame's addresses and page count are unchanged, and no missed_o is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| part_page_i | input | 5 | First transmit page; the receive ring is the pages below it |
| rx_start_i | input | 1 | Frame start pulse from the MAC side |
| rx_len_i | input | 11 | Frame data length in bytes, valid with rx_start_i |
| rx_byte_i | input | 1 | One data byte is being written this cycle |
| rx_end_i | input | 1 | Frame end pulse |
| mem_we_o | output | 1 | Buffer write enable for the current data byte |
| mem_addr_o | output | 13 | Buffer byte address {page, offset} |
| missed_o | output | 1 | Frame dropped (one cycle) |
| cmd_we_i | input | 1 | Command strobe |
| cmd_i | input | 4 | Command code: 1 release, 2 transmit, 3 clear transmit flag |
| desc_o | output | 8 | Oldest frame: [7:5] page count, [4:0] start page |
| rx_irq_o | output | 1 | Unreleased frames present |
| txd_we_i | input | 1 | Transmit request byte strobe |
| txd_i | input | 8 | Transmit request byte |
| tx_done_i | input | 1 | Send completed |
| tx_go_o | output | 1 | Start send (one cycle) |
| tx_len_o | output | 16 | Loaded byte count |
| tx_page_o | output | 5 | Loaded start page |
| tx_irq_o | output | 1 | Transmit complete flag |

## Verification
Frames with random lengths from 0 to 1900 bytes are mixed with random releases on a 23-page ring. This covers single-page frames, frames that span several pages and wrap past the last receive page, and frames that are too long for a 3-bit count. A reduced 3-page ring makes the exact-fit, one-page-short and release-on-empty cases easy to reach. That separates a wrong free-page count from a wrong wrap point. A second start pulse inside a frame shows whether the allocator restarts. Transmit checks load an asymmetric byte count so that a swapped MSB/LSB order is visible, and they apply done and clear in the same cycle.

// File: rtl/rxpg_pkg.sv
package rxpg_pkg;
  localparam int PAGE_W = 5;
  localparam int OFF_W  = 8;
  localparam int CNT_W  = 3;
  localparam int LEN_W  = 11;
  localparam int HDR_B  = 4;

  typedef enum logic [3:0] {
    CMD_NOP     = 4'h0,
    CMD_RELEASE = 4'h1,
    CMD_XMIT    = 4'h2,
    CMD_TXACK   = 4'h3
  } cmd_e;
endpackage

// File: rtl/rxpg_alloc.sv
module rxpg_alloc #(
  parameter int PAGE_W = rxpg_pkg::PAGE_W,
  parameter int OFF_W  = rxpg_pkg::OFF_W,
  parameter int CNT_W  = rxpg_pkg::CNT_W,
  parameter int LEN_W  = rxpg_pkg::LEN_W,
  parameter int HDR_B  = rxpg_pkg::HDR_B,
  localparam int ADDR_W = PAGE_W + OFF_W,
  localparam int NEED_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAGE_W-1:0] part_i,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              byte_i,
  input  logic              end_i,
  input  logic              rel_i,
  input  logic [CNT_W-1:0]  rel_cnt_i,
  output logic              push_o,
  output logic [CNT_W-1:0]  push_cnt_o,
  output logic              missed_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PAGE_W-1:0] rd_page_o
);
  localparam int MAX_CNT = (1 << CNT_W) - 1;
  localparam int ROUND   = HDR_B + (1 << OFF_W) - 1;

  logic [PAGE_W-1:0] wr_q, rd_q, cur_pg_q;
  logic [OFF_W-1:0]  cur_off_q;
  logic [PAGE_W:0]   used_q, free_pg, add_pg, sub_pg;
  logic [CNT_W-1:0]  cnt_q;
  logic              active_q, missed_q;
  logic [NEED_W-1:0] need;
  logic              take, fits, accept;

  function automatic logic [PAGE_W-1:0] ring_add(input logic [PAGE_W-1:0] p,
                                                 input logic [PAGE_W:0] n,
                                                 input logic [PAGE_W-1:0] lim);
    logic [PAGE_W+1:0] s;
    s = {2'b00, p} + {1'b0, n};
    if (s >= {2'b00, lim}) s = s - {2'b00, lim};
    return s[PAGE_W-1:0];
  endfunction

  // whole pages for header plus data
  assign need    = ({1'b0, len_i} + NEED_W'(ROUND)) >> OFF_W;
  assign free_pg = {1'b0, part_i} - used_q;
  assign take    = start_i && !active_q;
  assign fits    = (need <= NEED_W'(MAX_CNT)) && (need <= NEED_W'(free_pg));
  assign accept  = take && fits;
  assign add_pg  = accept ? need[PAGE_W:0] : '0;
  assign sub_pg  = rel_i ? (PAGE_W+1)'(rel_cnt_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= '0;
      rd_q      <= '0;
      cur_pg_q  <= '0;
      cur_off_q <= '0;
      used_q    <= '0;
      cnt_q     <= '0;
      active_q  <= 1'b0;
      missed_q  <= 1'b0;
    end else begin
      missed_q <= take && !fits;
      used_q   <= used_q + add_pg - sub_pg;
      if (rel_i) rd_q <= ring_add(rd_q, sub_pg, part_i);
      if (accept) begin
        active_q  <= 1'b1;
        cur_pg_q  <= wr_q;
        cur_off_q <= OFF_W'(HDR_B);
        cnt_q     <= need[CNT_W-1:0];
        wr_q      <= ring_add(wr_q, need[PAGE_W:0], part_i);
      end else if (active_q) begin
        if (byte_i) begin
          cur_off_q <= cur_off_q + 1'b1;
          if (&cur_off_q) cur_pg_q <= ring_add(cur_pg_q, (PAGE_W+1)'(1), part_i);
        end
        if (end_i) active_q <= 1'b0;
      end
    end
  end

  assign push_o     = active_q && end_i;
  assign push_cnt_o = cnt_q;
  assign missed_o   = missed_q;
  assign mem_we_o   = active_q && byte_i;
  assign mem_addr_o = {cur_pg_q, cur_off_q};
  assign rd_page_o  = rd_q;

  AST_WE_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[ADDR_W-1:OFF_W] < part_i)); // R3
  AST_USED_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_q <= {1'b0, part_i}); // R4
  AST_MISS_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    missed_o |-> $past(start_i)); // R4
  AST_EMPTY_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_q == '0) |-> (rd_q == wr_q)); // R5
endmodule

// File: rtl/rxpg_fifo.sv
module rxpg_fifo #(
  parameter int W       = rxpg_pkg::CNT_W,
  parameter int DEPTH_W = rxpg_pkg::PAGE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  localparam int DEPTH = 1 << DEPTH_W;

  logic [W-1:0]       mem_q [DEPTH];
  logic [DEPTH_W-1:0] wp_q, rp_q;
  logic [DEPTH_W:0]   n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
      n_q  <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
      n_q <= n_q + (DEPTH_W+1)'(push_i) - (DEPTH_W+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end

  assign head_o  = mem_q[rp_q];
  assign empty_o = (n_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (n_q < (DEPTH_W+1)'(DEPTH))); // R4
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (n_q != '0)); // R5
endmodule

// File: rtl/rxpg_tx.sv
module rxpg_tx #(
  parameter int PAGE_W = rxpg_pkg::PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        data_i,
  input  logic              go_i,
  input  logic              done_i,
  input  logic              ack_i,
  output logic              go_o,
  output logic [15:0]       len_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              irq_o
);
  logic [1:0]        idx_q;
  logic [7:0]        hi_q, lo_q;
  logic [PAGE_W-1:0] pg_q;
  logic              go_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      pg_q  <= '0;
      go_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (we_i) begin
        case (idx_q)
          2'd0:    hi_q <= data_i;
          2'd1:    lo_q <= data_i;
          default: pg_q <= data_i[PAGE_W-1:0];
        endcase
        idx_q <= (idx_q == 2'd2) ? 2'd0 : idx_q + 1'b1;
      end
      go_q <= go_i;
      if (done_i)     irq_q <= 1'b1;
      else if (ack_i) irq_q <= 1'b0;
    end
  end

  assign go_o   = go_q;
  assign len_o  = {hi_q, lo_q};
  assign page_o = pg_q;
  assign irq_o  = irq_q;

  AST_GO_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $past(go_i)); // R7
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> irq_o); // R8
  AST_IRQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !done_i) |=> !irq_o); // R8
endmodule

// File: rtl/rxpg_ring.sv
module rxpg_ring
  import rxpg_pkg::*;
#(
  parameter int P_W = rxpg_pkg::PAGE_W,
  parameter int O_W = rxpg_pkg::OFF_W,
  parameter int C_W = rxpg_pkg::CNT_W,
  parameter int L_W = rxpg_pkg::LEN_W,
  localparam int A_W = P_W + O_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [P_W-1:0] part_page_i,
  input  logic           rx_start_i,
  input  logic [L_W-1:0] rx_len_i,
  input  logic           rx_byte_i,
  input  logic           rx_end_i,
  output logic           mem_we_o,
  output logic [A_W-1:0] mem_addr_o,
  output logic           missed_o,
  input  logic           cmd_we_i,
  input  logic [3:0]     cmd_i,
  output logic [C_W+P_W-1:0] desc_o,
  output logic           rx_irq_o,
  input  logic           txd_we_i,
  input  logic [7:0]     txd_i,
  input  logic           tx_done_i,
  output logic           tx_go_o,
  output logic [15:0]    tx_len_o,
  output logic [P_W-1:0] tx_page_o,
  output logic           tx_irq_o
);
  logic           push, empty, rel;
  logic [C_W-1:0] push_cnt, head;
  logic [P_W-1:0] rd_page;

  assign rel = cmd_we_i && (cmd_i == CMD_RELEASE) && !empty;

  rxpg_alloc #(.PAGE_W(P_W), .OFF_W(O_W), .CNT_W(C_W), .LEN_W(L_W)) u_alloc (
    .clk_i, .rst_ni,
    .part_i    (part_page_i),
    .start_i   (rx_start_i),
    .len_i     (rx_len_i),
    .byte_i    (rx_byte_i),
    .end_i     (rx_end_i),
    .rel_i     (rel),
    .rel_cnt_i (head),
    .push_o    (push),
    .push_cnt_o(push_cnt),
    .missed_o  (missed_o),
    .mem_we_o  (mem_we_o),
    .mem_addr_o(mem_addr_o),
    .rd_page_o (rd_page)
  );

  rxpg_fifo #(.W(C_W), .DEPTH_W(P_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (push),
    .data_i (push_cnt),
    .pop_i  (rel),
    .head_o (head),
    .empty_o(empty)
  );

  rxpg_tx #(.PAGE_W(P_W)) u_tx (
    .clk_i, .rst_ni,
    .we_i  (txd_we_i),
    .data_i(txd_i),
    .go_i  (cmd_we_i && (cmd_i == CMD_XMIT)),
    .done_i(tx_done_i),
    .ack_i (cmd_we_i && (cmd_i == CMD_TXACK)),
    .go_o  (tx_go_o),
    .len_o (tx_len_o),
    .page_o(tx_page_o),
    .irq_o (tx_irq_o)
  );

  assign rx_irq_o = !empty;
  assign desc_o   = {(empty ? '0 : head), rd_page};

  AST_IRQ_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> rx_irq_o); // R6
endmodule

// File: tb/rxpg_ring_test.sv
module rxpg_ring_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  part = 5'h17;
  logic        rx_start = 0, rx_byte = 0, rx_end = 0;
  logic [10:0] rx_len = '0;
  logic        cmd_we = 0;
  logic [3:0]  cmd = '0;
  logic        txd_we = 0, tx_done = 0;
  logic [7:0]  txd = '0;
  logic        mem_we, missed, rx_irq, tx_go, tx_irq;
  logic [12:0] mem_addr;
  logic [7:0]  desc;
  logic [15:0] tx_len;
  logic [4:0]  tx_page;

  int checks = 0, fails = 0;
  bit done = 0;
  int q[32];
  int qh, qt, qn, m_wr, m_rd, m_used;

  always #4 clk = ~clk;

  rxpg_ring uut (
    .clk_i(clk), .rst_ni(rst_n), .part_page_i(part),
    .rx_start_i(rx_start), .rx_len_i(rx_len), .rx_byte_i(rx_byte), .rx_end_i(rx_end),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .missed_o(missed),
    .cmd_we_i(cmd_we), .cmd_i(cmd), .desc_o(desc), .rx_irq_o(rx_irq),
    .txd_we_i(txd_we), .txd_i(txd), .tx_done_i(tx_done),
    .tx_go_o(tx_go), .tx_len_o(tx_len), .tx_page_o(tx_page), .tx_irq_o(tx_irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_add(int p, int n);
    return (p + n >= int'(part)) ? p + n - int'(part) : p + n;
  endfunction

  function automatic int exp_desc();
    return (qn != 0) ? ((q[qh] << 5) | m_rd) : m_rd;
  endfunction

  task automatic chk_state(string req);
    chk({req, " desc"}, int'(desc), exp_desc());
    chk("R6 rx_irq", int'(rx_irq), int'(qn != 0));
  endtask

  task automatic do_reset(logic [4:0] p);
    @(negedge clk);
    rst_n = 1'b0; part = p;
    rx_start = 0; rx_byte = 0; rx_end = 0; cmd_we = 0; txd_we = 0; tx_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    qh = 0; qt = 0; qn = 0; m_wr = 0; m_rd = 0; m_used = 0;
  endtask

  // restart_at >= 0 pulses a second start inside the frame (R10)
  task automatic frame(int len, int restart_at);
    int need, nb, start_pg, off;
    bit ok;
    need = (len + 259) / 256;
    ok = (need <= 7) && (need <= int'(part) - m_used);
    start_pg = m_wr;
    @(negedge clk);
    rx_start = 1; rx_len = 11'(len);
    @(negedge clk);
    rx_start = 0;
    chk(ok ? "R4 missed low on accept" : "R4 missed on drop", int'(missed), int'(!ok));
    if (ok) begin
      m_used += need; m_wr = m_add(m_wr, need);
    end
    nb = ok ? len : 8;
    for (int i = 0; i < nb; i++) begin
      rx_byte = 1;
      if (i == restart_at) begin rx_start = 1; rx_len = 11'd5; end
      #1;
      if (ok) begin
        off = 4 + i;
        chk("R3 we", int'(mem_we), 1);
        chk("R3 addr", int'(mem_addr), m_add(start_pg, off / 256) * 256 + off % 256);
      end else chk("R4 no write", int'(mem_we), 0);
      @(negedge clk);
      rx_start = 0;
      if (i == restart_at) chk("R10 no missed", int'(missed), 0);
    end
    rx_byte = 0; rx_end = 1;
    @(negedge clk);
    rx_end = 0;
    if (ok) begin
      q[qt] = need; qt = (qt + 1) % 32; qn++;
    end
    chk_state(ok ? "R2" : "R4");
  endtask

  task automatic release_one();
    @(negedge clk);
    cmd_we = 1; cmd = 4'h1;
    @(negedge clk);
    cmd_we = 0;
    if (qn != 0) begin
      m_used -= q[qh]; m_rd = m_add(m_rd, q[qh]); qh = (qh + 1) % 32; qn--;
    end
    chk_state("R5");
  endtask

  task automatic tx_cmd(logic [3:0] c, logic done_too);
    @(negedge clk);
    cmd_we = 1; cmd = c; tx_done = done_too;
    @(negedge clk);
    cmd_we = 0; tx_done = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset(5'h17);
    @(negedge clk);
    chk("R1 desc", int'(desc), 0);
    chk("R1 rx_irq", int'(rx_irq), 0);
    chk("R1 tx_irq", int'(tx_irq), 0);
    chk("R1 missed", int'(missed), 0);
    chk("R1 tx_go", int'(tx_go), 0);

    // R9: 23-page ring, random frames and releases
    frame(0, -1);
    frame(252, -1);
    frame(253, -1);
    frame(1790, -1);
    for (int it = 0; it < 70; it++) begin
      if (qn != 0 && ($urandom % 3) == 0) release_one();
      else frame(int'($urandom_range(0, 1900)), -1);
    end
    while (qn != 0) release_one();
    release_one();

    // R9 small ring: exact fit, shortage, wrap
    do_reset(5'd3);
    frame(764, -1);
    frame(10, -1);
    release_one();
    release_one();
    frame(300, -1);
    frame(300, -1);
    release_one();
    frame(300, -1);
    frame(100, 20);
    release_one();
    release_one();

    // R7 transmit request
    @(negedge clk);
    txd_we = 1; txd = 8'h05; @(negedge clk);
    txd = 8'hEA; @(negedge clk);
    txd = 8'hF7; @(negedge clk);
    txd_we = 0;
    @(negedge clk);
    cmd_we = 1; cmd = 4'h2;
    @(negedge clk);
    cmd_we = 0;
    chk("R7 go", int'(tx_go), 1);
    chk("R7 len", int'(tx_len), 16'h05EA);
    chk("R7 page", int'(tx_page), 5'h17);
    @(negedge clk);
    chk("R7 go pulse", int'(tx_go), 0);

    // R8 transmit flag
    @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
    chk("R8 set", int'(tx_irq), 1);
    tx_cmd(4'h3, 1'b0);
    chk("R8 clear", int'(tx_irq), 0);
    tx_cmd(4'h3, 1'b1);
    chk("R8 set wins", int'(tx_irq), 1);
    tx_cmd(4'h0, 1'b0);
    chk("R8 nop keeps", int'(tx_irq), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule